// File: doc/BRIEF.md
# UART Data Buffer with Watermark Status

This block is the byte buffer that sits between a UART's bus-side data register and its serial shifter. It stores 8-bit characters in arrival order and keeps an occupancy count. Two status flags come from comparing that count with programmable thresholds. The transmit-space flag is raised while the count is at or below the transmit threshold. The receive-ready flag is raised while the count is at or above the receive threshold.

The buffer has two modes. In queue mode it holds `DEPTH` entries. In single-slot mode it holds exactly one entry, and the thresholds are forced to 0 (transmit) and 1 (receive), so the flags mean "slot free" and "slot filled". A change of mode empties the buffer.

Faults are recorded in sticky flags. A push into a full buffer is dropped and sets the overflow flag. A pop from an empty buffer sets the underflow flag and returns the most recently popped byte. A flush empties the buffer in one cycle. The current capacity is reported as a 3-bit size code.

Top module: `uart_wm_fifo`

## Requirements
- R1: After reset the count is 0, the overflow and underflow flags are 0, `pop_data` is 0 and the transmit-space flag is 1.
- R2: In queue mode the buffer accepts up to `DEPTH` (8) bytes and returns them in push order. `count` gives the number held one cycle after each push or pop edge. `pop_data` shows the oldest byte while the buffer is not empty.
- R3: A push while the buffer is full and no pop is presented is dropped. The count is unchanged, the held data is unchanged, and `overflow` becomes 1 and stays 1 until flush or reset.
- R4: A pop while the buffer is empty leaves the count at 0 and sets `underflow`, which stays 1 until flush or reset. While the buffer is empty, `pop_data` shows the last byte that was popped.
- R5: In queue mode `tx_space` is 1 exactly when `count` <= `tx_water`.
- R6: In queue mode `rx_ready` is 1 exactly when `count` >= `rx_water`.
- R7: In single-slot mode (`fifo_en`=0) the capacity is 1, and `tx_water` and `rx_water` have no effect. `tx_space` is 1 only at count 0, and `rx_ready` is 1 only at count 1.
- R8: `size_code` encodes the capacity as follows: 0 means 1 entry, 1 means 4, 2 means 8, 3 means 16, 4 means 32, 5 means 64 and 6 means 128. Code 7 is never produced. Queue mode with `DEPTH`=8 reports 2, and single-slot mode reports 0.
- R9: `flush` empties the buffer in one cycle and clears both sticky flags. A push or pop in the same cycle is ignored.
- R10: A push and a pop in the same cycle on a non-empty buffer leave the count unchanged, even when the buffer is full.
- R11: A change of `fifo_en` takes effect after one clock edge and empties the buffer in that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single-slot mode |
| flush | input | 1 | Empty the buffer and clear the sticky flags |
| tx_water | input | 4 | Transmit threshold (queue mode) |
| rx_water | input | 4 | Receive threshold (queue mode) |
| push | input | 1 | Write strobe |
| push_data | input | 8 | Byte to write |
| pop | input | 1 | Read strobe |
| pop_data | output | 8 | Oldest byte, or the last popped byte when empty |
| count | output | 4 | Number of bytes held |
| size_code | output | 3 | Encoded capacity |
| tx_space | output | 1 | Count is at or below the transmit threshold |
| rx_ready | output | 1 | Count is at or above the receive threshold |
| overflow | output | 1 | Sticky: a push was dropped |
| underflow | output | 1 | Sticky: a pop found the buffer empty |

## Verification
The first pattern fills the queue one byte at a time and then drains it, checking order and count. The same fill is repeated with thresholds in mid-range, so that both flags change at the threshold and not at empty or full. Pushes beyond capacity and pops beyond empty show whether a dropped byte or a stale read reaches the data path, and whether the sticky flags hold. A push and a pop on the same edge, a flush mid-fill and a mode switch with data held separate the ways the count can change. The single-slot pattern is run with non-zero thresholds to show they are ignored.

// File: rtl/uwf_pkg.sv
package uwf_pkg;
    // capacity -> 3-bit code; 7 marks a capacity outside the encoded set
    function automatic logic [2:0] size_to_code(input int unsigned cap);
        case (cap)
            1:       return 3'd0;
            4:       return 3'd1;
            8:       return 3'd2;
            16:      return 3'd3;
            32:      return 3'd4;
            64:      return 3'd5;
            128:     return 3'd6;
            default: return 3'd7;
        endcase
    endfunction
endpackage

// File: rtl/uwf_store.sv
module uwf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_ptr] <= wr_data;
    end

    assign rd_data = mem_q[rd_ptr];
endmodule

// File: rtl/uwf_ctrl.sv
module uwf_ctrl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              flush,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] last_data,
    output logic              mode_q,
    output logic              ovf,
    output logic              unf
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [PTR_W-1:0]  wr;
        logic [PTR_W-1:0]  rd;
        logic [DATA_W-1:0] last;
        logic              mode;
        logic              ovf;
        logic              unf;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [CNT_W-1:0] cap;
    logic             clear, take, put;

    assign cap   = st_q.mode ? CNT_W'(DEPTH) : CNT_W'(1);
    assign clear = flush || (fifo_en != st_q.mode);
    assign take  = !clear && pop && (st_q.cnt != '0);
    assign put   = !clear && push && ((st_q.cnt != cap) || take);

    always_comb begin
        st_d      = st_q;
        st_d.mode = fifo_en;
        if (clear) begin
            st_d.cnt = '0;
            st_d.wr  = '0;
            st_d.rd  = '0;
            if (flush) begin
                st_d.ovf = 1'b0;
                st_d.unf = 1'b0;
            end
        end else begin
            if (put)  st_d.wr = st_q.wr + 1'b1;
            if (take) begin
                st_d.rd   = st_q.rd + 1'b1;
                st_d.last = rd_data;
            end
            if (put && !take)      st_d.cnt = st_q.cnt + 1'b1;
            else if (take && !put) st_d.cnt = st_q.cnt - 1'b1;
            if (push && !put)                   st_d.ovf = 1'b1;
            if (pop && (st_q.cnt == '0))        st_d.unf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en     = put;
    assign wr_ptr    = st_q.wr;
    assign rd_ptr    = st_q.rd;
    assign count     = st_q.cnt;
    assign last_data = st_q.last;
    assign mode_q    = st_q.mode;
    assign ovf       = st_q.ovf;
    assign unf       = st_q.unf;
endmodule

// File: rtl/uwf_status.sv
module uwf_status #(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             mode_q,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] tx_water,
    input  logic [CNT_W-1:0] rx_water,
    output logic             tx_space,
    output logic             rx_ready,
    output logic [2:0]       size_code
);
    import uwf_pkg::*;

    localparam logic [2:0] QUEUE_CODE  = size_to_code(DEPTH);
    localparam logic [2:0] SINGLE_CODE = size_to_code(1);

    logic [CNT_W-1:0] tx_eff, rx_eff;

    always_comb begin
        tx_eff    = mode_q ? tx_water : CNT_W'(0);
        rx_eff    = mode_q ? rx_water : CNT_W'(1);
        tx_space  = (count <= tx_eff);
        rx_ready  = (count >= rx_eff);
        size_code = mode_q ? QUEUE_CODE : SINGLE_CODE;
    end
endmodule

// File: rtl/uart_wm_fifo.sv
module uart_wm_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              flush,
    input  logic [CNT_W-1:0]  tx_water,
    input  logic [CNT_W-1:0]  rx_water,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic [2:0]        size_code,
    output logic              tx_space,
    output logic              rx_ready,
    output logic              overflow,
    output logic              underflow
);
    logic              wr_en, mode_q;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [DATA_W-1:0] rd_data, last_data;

    uwf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(push_data),
        .rd_ptr(rd_ptr), .rd_data(rd_data)
    );

    uwf_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush),
        .push(push), .pop(pop), .rd_data(rd_data), .wr_en(wr_en),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count),
        .last_data(last_data), .mode_q(mode_q), .ovf(overflow), .unf(underflow)
    );

    uwf_status #(.DEPTH(DEPTH)) u_status (
        .mode_q(mode_q), .count(count), .tx_water(tx_water), .rx_water(rx_water),
        .tx_space(tx_space), .rx_ready(rx_ready), .size_code(size_code)
    );

    assign pop_data = (count == '0) ? last_data : rd_data;
endmodule

// File: rtl/uwf_checker.sv
module uwf_checker #(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             flush,
    input logic             push,
    input logic             pop,
    input logic             mode_q,
    input logic [CNT_W-1:0] count,
    input logic             tx_space,
    input logic             rx_ready,
    input logic             overflow,
    input logic             underflow
);
    logic [CNT_W-1:0] cap;
    logic             steady;
    assign cap    = mode_q ? CNT_W'(DEPTH) : CNT_W'(1);
    assign steady = !flush && (fifo_en == mode_q);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= cap);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && push && !pop && count == cap) |=> (overflow && $stable(count)));

    assert_sticky_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);

    assert_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && pop && !push && count == '0) |=> (underflow && count == '0));

    assert_single_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (tx_space == (count == '0)) && (rx_ready == (count != '0)));

    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && !overflow && !underflow));

    assert_pair_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && push && pop && count != '0) |=> $stable(count));

    assert_mode_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != mode_q) |=> count == '0);
endmodule

bind uart_wm_fifo uwf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush), .push(push),
    .pop(pop), .mode_q(mode_q), .count(count), .tx_space(tx_space),
    .rx_ready(rx_ready), .overflow(overflow), .underflow(underflow)
);

// File: tb/sim_uart_wm_fifo.sv
`timescale 1ns/1ps
module sim_uart_wm_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1, flush = 1'b0, push = 1'b0, pop = 1'b0;
    logic [3:0] tx_water = 4'd0, rx_water = 4'd1;
    logic [7:0] push_data = 8'h00;
    logic [7:0] pop_data;
    logic [3:0] count;
    logic [2:0] size_code;
    logic       tx_space, rx_ready, overflow, underflow;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_wm_fifo u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush),
        .tx_water(tx_water), .rx_water(rx_water), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(pop_data), .count(count),
        .size_code(size_code), .tx_space(tx_space), .rx_ready(rx_ready),
        .overflow(overflow), .underflow(underflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_push(input logic [7:0] d);
        @(negedge clk); push = 1'b1; push_data = d;
        @(negedge clk); push = 1'b0;
    endtask

    task automatic do_pop_chk(input string req, input logic [7:0] exp);
        @(negedge clk); check(req, pop_data, exp); pop = 1'b1;
        @(negedge clk); pop = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 count", count, 0);
        check("R1 overflow", overflow, 0);
        check("R1 underflow", underflow, 0);
        check("R1 pop_data", pop_data, 0);
        check("R1 tx_space", tx_space, 1);
    endtask

    task automatic t_order();
        @(negedge clk);
        check("R8 queue code", size_code, 2);
        for (int i = 0; i < 8; i++) begin
            do_push(8'hA0 + 8'(i));
            check("R2 count up", count, i + 1);
        end
        for (int i = 0; i < 8; i++) begin
            do_pop_chk("R2 order", 8'hA0 + 8'(i));
            check("R2 count down", count, 7 - i);
        end
    endtask

    task automatic t_watermark();
        tx_water = 4'd3; rx_water = 4'd5;
        @(negedge clk);
        check("R5 tx at 0", tx_space, 1);
        check("R6 rx at 0", rx_ready, 0);
        for (int i = 1; i <= 8; i++) begin
            do_push(8'(i));
            check("R5 tx_space", tx_space, (i <= 3));
            check("R6 rx_ready", rx_ready, (i >= 5));
        end
        do_flush();
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 8; i++) do_push(8'h10 + 8'(i));
        check("R3 no ovf yet", overflow, 0);
        do_push(8'hEE);
        check("R3 overflow set", overflow, 1);
        check("R3 count held", count, 8);
        do_pop_chk("R3 head intact", 8'h10);
        check("R3 sticky", overflow, 1);
        for (int i = 1; i < 8; i++) do_pop_chk("R3 drop not stored", 8'h10 + 8'(i));
        check("R3 drained", count, 0);
    endtask

    task automatic t_underflow();
        check("R4 no unf yet", underflow, 0);
        check("R4 last data shown", pop_data, 8'h17);
        @(negedge clk); pop = 1'b1;
        @(negedge clk); pop = 1'b0;
        check("R4 underflow set", underflow, 1);
        check("R4 count stays 0", count, 0);
        check("R4 pop_data last", pop_data, 8'h17);
    endtask

    task automatic t_flush();
        do_push(8'h31); do_push(8'h32); do_push(8'h33);
        @(negedge clk); flush = 1'b1; push = 1'b1; push_data = 8'h99;
        @(negedge clk); flush = 1'b0; push = 1'b0;
        check("R9 count cleared", count, 0);
        check("R9 ovf cleared", overflow, 0);
        check("R9 unf cleared", underflow, 0);
        do_push(8'h44);
        check("R9 fresh count", count, 1);
        do_pop_chk("R9 fresh data", 8'h44);
    endtask

    task automatic t_simul();
        do_push(8'h51); do_push(8'h52);
        @(negedge clk); push = 1'b1; pop = 1'b1; push_data = 8'h53;
        @(negedge clk); push = 1'b0; pop = 1'b0;
        check("R10 count same", count, 2);
        for (int i = 0; i < 6; i++) do_push(8'h60 + 8'(i));
        @(negedge clk); push = 1'b1; pop = 1'b1; push_data = 8'h70;
        @(negedge clk); push = 1'b0; pop = 1'b0;
        check("R10 full count same", count, 8);
        check("R10 no ovf when full pair", overflow, 0);
        do_pop_chk("R10 order", 8'h53);
    endtask

    task automatic t_single();
        tx_water = 4'd5; rx_water = 4'd5;
        @(negedge clk); fifo_en = 1'b0;
        @(negedge clk);
        check("R11 switch empties", count, 0);
        check("R8 single code", size_code, 0);
        check("R7 tx empty", tx_space, 1);
        check("R7 rx empty", rx_ready, 0);
        do_push(8'h81);
        check("R7 count 1", count, 1);
        check("R7 tx full", tx_space, 0);
        check("R7 rx full", rx_ready, 1);
        do_push(8'h82);
        check("R7 second dropped", count, 1);
        check("R7 overflow", overflow, 1);
        do_pop_chk("R7 data", 8'h81);
        check("R7 tx after pop", tx_space, 1);
        do_push(8'h83);
        @(negedge clk); fifo_en = 1'b1;
        @(negedge clk);
        check("R11 back to queue empties", count, 0);
        check("R8 code back", size_code, 2);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_order();
        t_watermark();
        t_overflow();
        t_underflow();
        t_flush();
        do_flush();
        t_simul();
        t_single();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule